// File: doc/BRIEF.md
# Sequential Label-Driven Row Reduction Tree

This block adds up the elements of one matrix row that arrive one per cycle or slower. A full binary adder tree for m elements would need m−1 adders. Here a chain of LEVELS stages does the same work, and each stage holds a single waiting operand and one pipelined adder. Stage l pairs the consecutive partial sums it receives and passes each pair's sum to stage l+1. A row of up to 2^LEVELS elements is therefore fully reduced by the time it leaves the last stage.

Each element carries a remaining-count label. A stage uses this label to recognise the final operand that reaches it for a row. If that operand has no waiting partner, the stage adds it to zero instead of stalling. After that final operand the stage is empty, so the next row can follow without a gap.

The adder is an integer adder with a parameterised pipeline depth. Valid and label bits travel beside the data in a delay line of the same depth. Inputs are widened by LEVELS bits on entry, so no row total can overflow.

Top module: `rt_reduce_tree`

## Requirements
- R1: During reset and afterwards, `out_valid` stays low as long as no row has been completed at the input.
- R2: For each row of m elements (1 ≤ m ≤ 2^LEVELS), the block raises `out_valid` for exactly one cycle, and `out_sum` then equals the arithmetic sum of the m elements.
- R3: Label encoding: the element sent k-th (k = 1..m) carries `in_label` = m−k+1, so the first element carries m and the last carries 1. Stage l treats an operand whose label is at most 2^l as its last operand for the row.
- R4: A row of one element comes out unchanged, apart from width extension.
- R5: `out_valid` rises on the clock edge that comes LEVELS×ADD_LAT−1 edges after the edge that accepts the row's last element, whatever the row length.
- R6: Rows sent back to back, with no idle cycle between them, give separate, correct totals in the order they were sent.
- R7: Idle cycles (`in_valid` low) between the elements of a row change neither the total nor the latency measured from the last element.
- R8: With sign extension selected (the default), `in_data` is two's complement and is sign-extended to SUM_W = DATA_W+LEVELS bits, so negative elements sum correctly.
- R9: A row of the maximum length 2^LEVELS, filled entirely with the most positive or entirely with the most negative DATA_W value, gives its exact total without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Element present this cycle |
| in_data | input | DATA_W | Element value |
| in_label | input | LEVELS+1 | Remaining-count label of the element (R3) |
| out_valid | output | 1 | One-cycle done pulse for a row total |
| out_sum | output | DATA_W+LEVELS | Row total, valid with `out_valid` |

## Verification
Suppose one stage keeps a stale waiting operand, or misses the last-operand test. That stage then either stalls a partial sum, so the row's done pulse never appears, or merges the stale value into the next row. The fault shows at `out_sum` in the next row's done cycle. A wrong delay line shows as a pulse off by cycles from the fixed LEVELS×ADD_LAT−1 edge count. A dropped or duplicated valid shows as a missing or extra pulse within one row latency. Back-to-back rows and gapped rows expose leftovers in the waiting slots at the very next total.

// File: rtl/rt_pkg.sv
package rt_pkg;

   typedef enum logic {
      EXT_ZERO = 1'b0,
      EXT_SIGN = 1'b1
   } rt_ext_e;

   localparam int unsigned RT_LAT_MIN    = 3;
   localparam int unsigned RT_LAT_MAX    = 11;
   localparam int unsigned RT_LEVELS_MAX = 24;

   // number of original elements one operand at a stage stands for
   function automatic int unsigned rt_span(input int unsigned level);
      return 32'd1 << level;
   endfunction

endpackage

// File: rtl/rt_add_pipe.sv
module rt_add_pipe #(
   parameter int unsigned W   = 32,
   parameter int unsigned LW  = 17,
   parameter int unsigned LAT = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  op_b,
   input  logic [LW-1:0] in_lab,
   output logic          out_v,
   output logic [W-1:0]  out_sum,
   output logic [LW-1:0] out_lab
);

   logic [LAT-1:0] v_q;
   logic [W-1:0]   s_q [LAT];
   logic [LW-1:0]  l_q [LAT];

   generate
      if (LAT == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q <= '0;
            else        v_q <= in_v;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) v_q <= '0;
            else        v_q <= {v_q[LAT-2:0], in_v};
         end
      end
   endgenerate

   // data and label follow the valid bit stage by stage
   always_ff @(posedge clk) begin
      s_q[0] <= op_a + op_b;
      l_q[0] <= in_lab;
      for (int i = 1; i < LAT; i++) begin
         s_q[i] <= s_q[i-1];
         l_q[i] <= l_q[i-1];
      end
   end

   assign out_v   = v_q[LAT-1];
   assign out_sum = s_q[LAT-1];
   assign out_lab = l_q[LAT-1];

endmodule

// File: rtl/rt_level.sv
module rt_level #(
   parameter int unsigned W     = 32,
   parameter int unsigned LW    = 17,
   parameter int unsigned LEVEL = 0,
   parameter int unsigned LAT   = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [W-1:0]  in_d,
   input  logic [LW-1:0] in_lab,
   output logic          out_v,
   output logic [W-1:0]  out_d,
   output logic [LW-1:0] out_lab,
   output logic          hold_o,
   output logic          fire_o
);

   localparam logic [LW-1:0] THRESH = LW'(rt_pkg::rt_span(LEVEL));

   logic          hold_v;
   logic [W-1:0]  hold_d;
   logic [LW-1:0] hold_lab;
   logic          is_last;
   logic          fire;
   logic [W-1:0]  add_a;
   logic [W-1:0]  add_b;
   logic [LW-1:0] add_lab;

   generate
      if (LEVEL == 0) begin : g_base
         assign is_last = (in_lab == LW'(1));
      end else begin : g_upper
         assign is_last = (in_lab <= THRESH);
      end
   endgenerate

   // pair with the waiting operand, or add a lone final operand to zero
   always_comb begin
      fire    = in_v && (hold_v || is_last);
      add_a   = hold_v ? hold_d   : in_d;
      add_b   = hold_v ? in_d     : '0;
      add_lab = hold_v ? hold_lab : in_lab;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
      end else if (in_v) begin
         if (hold_v)        hold_v <= 1'b0;
         else if (!is_last) hold_v <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (in_v && !hold_v && !is_last) begin
         hold_d   <= in_d;
         hold_lab <= in_lab;
      end
   end

   rt_add_pipe #(
      .W   (W),
      .LW  (LW),
      .LAT (LAT)
   ) add_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_v    (fire),
      .op_a    (add_a),
      .op_b    (add_b),
      .in_lab  (add_lab),
      .out_v   (out_v),
      .out_sum (out_d),
      .out_lab (out_lab)
   );

   assign hold_o = hold_v;
   assign fire_o = fire;

endmodule

// File: rtl/rt_reduce_tree.sv
module rt_reduce_tree import rt_pkg::*; #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned LEVELS   = 16,
   parameter int unsigned ADD_LAT  = 11,
   parameter rt_ext_e     EXT_MODE = EXT_SIGN,
   localparam int unsigned SUM_W   = DATA_W + LEVELS,
   localparam int unsigned LBL_W   = LEVELS + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [LBL_W-1:0]  in_label,
   output logic              out_valid,
   output logic [SUM_W-1:0]  out_sum
);

   generate
      if (LEVELS < 1 || LEVELS > RT_LEVELS_MAX) begin : g_bad_levels
         $error("rt_reduce_tree: LEVELS out of range");
      end
      if (ADD_LAT < RT_LAT_MIN || ADD_LAT > RT_LAT_MAX) begin : g_bad_lat
         $error("rt_reduce_tree: ADD_LAT out of range");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("rt_reduce_tree: DATA_W too small");
      end
   endgenerate

   logic [LEVELS:0]    lvl_v;
   logic [SUM_W-1:0]   lvl_d   [LEVELS+1];
   logic [LBL_W-1:0]   lvl_lab [LEVELS+1];
   logic [LEVELS-1:0]  hold_v;
   logic [LEVELS-1:0]  fire_v;
   logic [SUM_W-1:0]   ext_d;

   generate
      if (EXT_MODE == EXT_SIGN) begin : g_sext
         assign ext_d = {{LEVELS{in_data[DATA_W-1]}}, in_data};
      end else begin : g_zext
         assign ext_d = {{LEVELS{1'b0}}, in_data};
      end
   endgenerate

   assign lvl_v[0]   = in_valid;
   assign lvl_d[0]   = ext_d;
   assign lvl_lab[0] = in_label;

   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
         rt_level #(
            .W     (SUM_W),
            .LW    (LBL_W),
            .LEVEL (l),
            .LAT   (ADD_LAT)
         ) lvl_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_v    (lvl_v[l]),
            .in_d    (lvl_d[l]),
            .in_lab  (lvl_lab[l]),
            .out_v   (lvl_v[l+1]),
            .out_d   (lvl_d[l+1]),
            .out_lab (lvl_lab[l+1]),
            .hold_o  (hold_v[l]),
            .fire_o  (fire_v[l])
         );
      end
   endgenerate

   assign out_valid = lvl_v[LEVELS];
   assign out_sum   = lvl_d[LEVELS];

endmodule

// File: rtl/rt_reduce_tree_chk.sv
module rt_reduce_tree_chk #(
   parameter int unsigned LEVELS  = 16,
   parameter int unsigned ADD_LAT = 11,
   parameter int unsigned LBL_W   = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [LBL_W-1:0]  in_label,
   input logic              out_valid,
   input logic [LEVELS:0]   lvl_v,
   input logic [LBL_W-1:0]  lvl_lab [LEVELS+1],
   input logic [LEVELS-1:0] hold_v,
   input logic [LEVELS-1:0] fire_v
);

   logic             row_open;
   logic [LBL_W-1:0] next_lab;
   logic [15:0]      pending;
   logic [7:0]       since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_open  <= 1'b0;
         next_lab  <= '0;
         pending   <= '0;
         since_rst <= '0;
      end else begin
         if (since_rst != 8'hFF) since_rst <= since_rst + 8'd1;
         if (in_valid) begin
            row_open <= (in_label > LBL_W'(1));
            next_lab <= in_label - LBL_W'(1);
         end
         pending <= pending + 16'(in_valid && in_label == LBL_W'(1))
                            - 16'(out_valid);
      end
   end

   // R3: labels count down by one inside a row
   assert_label_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && row_open) |-> (in_label == next_lab));

   // R3: labels lie in 1 .. 2^LEVELS
   assert_label_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (in_label != '0 && in_label <= (LBL_W'(1) << LEVELS)));

   // R2: a done pulse only for a row whose last element was accepted
   assert_done_has_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (pending != 16'd0));

   generate
      for (genvar l = 0; l < LEVELS; l++) begin : g_lc
         // R3: the last operand of a row leaves a stage empty
         assert_hold_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (lvl_v[l] && lvl_lab[l] <= (LBL_W'(1) << l)) |=> !hold_v[l]);

         // R5: each stage delivers exactly ADD_LAT cycles after it fires
         assert_stage_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 8'(ADD_LAT + 1)) |-> (lvl_v[l+1] == $past(fire_v[l], ADD_LAT)));
      end
   endgenerate

endmodule

bind rt_reduce_tree rt_reduce_tree_chk #(
   .LEVELS  (LEVELS),
   .ADD_LAT (ADD_LAT),
   .LBL_W   (LBL_W)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_label  (in_label),
   .out_valid (out_valid),
   .lvl_v     (lvl_v),
   .lvl_lab   (lvl_lab),
   .hold_v    (hold_v),
   .fire_v    (fire_v)
);

// File: tb/rt_reduce_tree_tb_top.sv
module rt_reduce_tree_tb_top;
   import rt_pkg::*;

   localparam int DW  = 16;
   localparam int LV  = 5;
   localparam int LAT = 3;
   localparam int SW  = DW + LV;
   localparam int LW  = LV + 1;
   localparam int ROW_LAT = LV * LAT - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic [LW-1:0] in_label = '0;
   logic          out_valid;
   logic [SW-1:0] out_sum;

   always #5 clk = ~clk;

   rt_reduce_tree #(
      .DATA_W   (DW),
      .LEVELS   (LV),
      .ADD_LAT  (LAT),
      .EXT_MODE (EXT_SIGN)
   ) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_label  (in_label),
      .out_valid (out_valid),
      .out_sum   (out_sum)
   );

   int     cyc = 0;
   int     checks = 0;
   int     fails = 0;
   int     res_n = 0;
   longint got_sum [64];
   int     got_cyc [64];
   longint vals [64];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n && out_valid && res_n < 64) begin
         got_sum[res_n] = longint'($signed(out_sum));
         got_cyc[res_n] = cyc;
         res_n++;
      end
   end

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc == 100000) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 100000);
         finish_run();
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic longint row_sum(input int m);
      longint s = 0;
      for (int i = 0; i < m; i++) s += vals[i];
      return s;
   endfunction

   function automatic void fill(input int m, input int seed);
      for (int i = 0; i < m; i++) vals[i] = longint'(((i * 37 + seed * 13) % 201) - 100);
   endfunction

   task automatic send_row(input int m, input int gap, input bit tail_idle, output int edge_o);
      for (int i = 0; i < m; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = DW'(vals[i]);
         in_label = LW'(m - i);
         if (i == m - 1) edge_o = cyc + 1;
         if (gap > 0 && i != m - 1) begin
            @(negedge clk);
            in_valid = 1'b0;
            repeat (gap - 1) @(negedge clk);
         end
      end
      if (tail_idle) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic wait_res(input int target);
      int t = 0;
      while (res_n < target && t < 2000) begin
         @(negedge clk);
         t++;
      end
   endtask

   task automatic run_row(input int m, input int gap, input string req);
      int base = res_n;
      int edge_c;
      longint exp_s = row_sum(m);
      send_row(m, gap, 1'b1, edge_c);
      wait_res(base + 1);
      repeat (ROW_LAT + 4) @(negedge clk);
      chk(res_n == base + 1, "R2", "done pulses for one row", res_n - base, 1);
      if (res_n > base) begin
         chk(got_sum[base] == exp_s, req, "row total", got_sum[base], exp_s);
         chk(got_cyc[base] - edge_c == ROW_LAT, "R5", "edges from last element to done",
             got_cyc[base] - edge_c, ROW_LAT);
      end
   endtask

   task automatic t_reset();
      int seen = 0;
      chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (out_valid) seen++;
      end
      chk(seen == 0, "R1", "pulses with no input", seen, 0);
   endtask

   task automatic t_single();
      vals[0] = -7;
      run_row(1, 0, "R4");
      vals[0] = 12345;
      run_row(1, 0, "R4");
   endtask

   task automatic t_five();
      // R3: five elements, labels 5..1, lone operands at the two lower stages
      vals[0] = 10; vals[1] = -3; vals[2] = 7; vals[3] = 100; vals[4] = -55;
      run_row(5, 0, "R3");
   endtask

   task automatic t_pow2();
      fill(8, 1);
      run_row(8, 0, "R2");
      fill(16, 2);
      run_row(16, 0, "R2");
      fill(13, 3);
      run_row(13, 0, "R2");
   endtask

   task automatic t_signed();
      for (int i = 0; i < 4; i++) vals[i] = -1;
      run_row(4, 0, "R8");
      fill(11, 4);
      for (int i = 0; i < 11; i++) vals[i] = -(vals[i] < 0 ? -vals[i] : vals[i]);
      run_row(11, 0, "R8");
   endtask

   task automatic t_max();
      for (int i = 0; i < 32; i++) vals[i] = 32767;
      run_row(32, 0, "R9");
      for (int i = 0; i < 32; i++) vals[i] = -32768;
      run_row(32, 0, "R9");
   endtask

   task automatic t_gaps();
      fill(7, 5);
      run_row(7, 2, "R7");
      fill(6, 6);
      run_row(6, 1, "R7");
   endtask

   task automatic t_b2b();
      int base = res_n;
      int e0, e1, e2;
      longint s0, s1, s2;
      fill(3, 7);  s0 = row_sum(3); send_row(3, 0, 1'b0, e0);
      vals[0] = -900; s1 = -900;    send_row(1, 0, 1'b0, e1);
      fill(6, 8);  s2 = row_sum(6); send_row(6, 0, 1'b1, e2);
      wait_res(base + 3);
      repeat (ROW_LAT + 4) @(negedge clk);
      chk(res_n == base + 3, "R6", "done pulses for three rows", res_n - base, 3);
      if (res_n >= base + 3) begin
         chk(got_sum[base]     == s0, "R6", "first row total",  got_sum[base],     s0);
         chk(got_sum[base + 1] == s1, "R6", "second row total", got_sum[base + 1], s1);
         chk(got_sum[base + 2] == s2, "R6", "third row total",  got_sum[base + 2], s2);
         chk(got_cyc[base + 1] - e1 == ROW_LAT, "R5", "latency of middle row",
             got_cyc[base + 1] - e1, ROW_LAT);
         chk(got_cyc[base + 2] - e2 == ROW_LAT, "R5", "latency of last row",
             got_cyc[base + 2] - e2, ROW_LAT);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_single();
      t_five();
      t_pow2();
      t_signed();
      t_max();
      t_gaps();
      t_b2b();
      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule